// File: doc/BRIEF.md
# Dual Down-Counting Timer Peripheral

The block holds two independent down-counting timers that share one word-addressed register window. Each timer has six word registers. Software loads a start value, picks periodic or single-run behaviour and turns the timer on. From then on the count falls by one on every cycle in which the tick-enable input is high. When the count expires, the timer latches an event flag. Each timer drives its own interrupt line, which is the event flag gated by that timer's interrupt-enable bit.

Two load paths exist. A direct load write restarts a running count at once. A staged load write changes only the value used at the next reload and leaves the current count alone. Bus writes take effect on the clock edge. Read data is a combinational function of the address and the current register state.

Top module: `dual_tick_timer`

## Requirements
- R1: Each timer owns six consecutive words. The first timer uses byte offsets 0x00 to 0x14. The second uses 0x18 to 0x2C, and its register index is the word index minus 6. The words, in order, are: count value (0), load value (1), staged load (2), control (3), raw event (4) and masked event (5). After reset every register reads zero.
- R2: A read at a byte offset of 0x30 or above returns zero. A write there changes no register.
- R3: Address bits 1:0 are ignored. A byte address is reduced to a word index by dropping them.
- R4: Each interrupt output equals the timer's raw event bit ANDed with control bit 1 (interrupt enable). Bit 0 of the masked event word reads back the same value.
- R5: Writing a value with bit 0 set to the raw event word clears the event bit. Writing bit 0 as zero leaves it unchanged. If an expiry and a clear fall in the same cycle, the bit ends up set.
- R6: A control write stores bits 2:0: bit 0 is enable, bit 1 is interrupt enable, bit 2 is single-run. Upper bits read back as zero. A write with enable set reloads the count from the load value and starts it. A write with enable clear stops the count and holds its value.
- R7: A load-value write stores the value. If the timer is enabled, the write also loads the count with that value and restarts counting. If the timer is disabled, the count is unchanged.
- R8: A staged-load write stores the value in both the staged-load and load words. The running count is not disturbed, so the new value is used only at the next reload.
- R9: While running, the count drops by exactly one on each cycle with tick enable high. It holds on every other cycle.
- R10: A tick that arrives while the count is zero is an expiry. It sets the raw event bit. In periodic mode (control bit 2 clear) it reloads the count from the load value and keeps running.
- R11: In single-run mode an expiry leaves the count at zero and stops it until the next control write or enabled load write.
- R12: The count-value and masked-event words are read-only. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Count tick; one decrement per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address within the window |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| irq_o | output | N_TIMERS | Per-timer interrupt lines |

## Verification
On every cycle, the embedded assertions check the following:
- a running count falls by exactly one per tick, and holds when there is no tick and no restarting write;
- an expiry always leaves the event flag set, even against a simultaneous clear;
- a write of one clears the flag and a write of zero keeps it;
- a single-run expiry parks the count at zero;
- a staged-load write does not move the count.

Only the bench scenarios can show the rest:
- the address decode across both timers and the ignored low address bits;
- the zero reads and dropped writes outside the window;
- the read-only words;
- the interrupt masking;
- which value a reload actually uses after staged and direct load writes.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;

   localparam int REGS_PER_TIMER = 6;
   localparam int CTL_W          = 3;

   typedef enum logic [2:0] {
      REG_VALUE  = 3'd0,
      REG_LOAD   = 3'd1,
      REG_STAGED = 3'd2,
      REG_CTRL   = 3'd3,
      REG_RAW    = 3'd4,
      REG_MASKED = 3'd5
   } reg_idx_e;

   // bit 0 enable, bit 1 interrupt enable, bit 2 single-run
   typedef struct packed {
      logic single_run;
      logic irq_en;
      logic enable;
   } ctrl_t;

endpackage

// File: rtl/dtmr_decode.sv
`timescale 1ns/1ps
module dtmr_decode
   import dtmr_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int N_TIMERS = 2,
   parameter int TSEL_W   = 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [TSEL_W-1:0] tsel_o,
   output reg_idx_e          ridx_o
);

   logic [31:0] word;
   logic        unused_lsb;

   assign word       = 32'(addr_i[ADDR_W-1:2]);
   assign unused_lsb = ^addr_i[1:0];

   always_comb begin
      hit_o  = 1'b0;
      tsel_o = '0;
      ridx_o = REG_VALUE;
      for (int t = 0; t < N_TIMERS; t++) begin
         if (word >= 32'(t * REGS_PER_TIMER) && word < 32'((t + 1) * REGS_PER_TIMER)) begin
            hit_o  = 1'b1;
            tsel_o = TSEL_W'(t);
            ridx_o = reg_idx_e'(3'(word - 32'(t * REGS_PER_TIMER)));
         end
      end
   end

endmodule

// File: rtl/dtmr_channel.sv
`timescale 1ns/1ps
module dtmr_channel
   import dtmr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_en_i,
   input  logic              wr_i,
   input  reg_idx_e          ridx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rd_word_o,
   output logic              irq_o
);

   logic [DATA_W-1:0] count_q, count_d;
   logic [DATA_W-1:0] load_q, load_d;
   logic [DATA_W-1:0] staged_q, staged_d;
   ctrl_t             ctrl_q, ctrl_d, ctrl_wr;
   logic              raw_q, raw_d;
   logic              run_q, run_d;
   logic              wr_ctrl, wr_load, wr_staged, wr_raw, expire;

   assign wr_ctrl   = wr_i && (ridx_i == REG_CTRL);
   assign wr_load   = wr_i && (ridx_i == REG_LOAD);
   assign wr_staged = wr_i && (ridx_i == REG_STAGED);
   assign wr_raw    = wr_i && (ridx_i == REG_RAW);
   assign ctrl_wr   = ctrl_t'(wdata_i[CTL_W-1:0]);
   assign expire    = run_q && tick_en_i && (count_q == '0);

   always_comb begin
      count_d  = count_q;
      load_d   = load_q;
      staged_d = staged_q;
      ctrl_d   = ctrl_q;
      raw_d    = raw_q;
      run_d    = run_q;
      // tick path
      if (run_q && tick_en_i) begin
         if (count_q == '0) begin
            if (ctrl_q.single_run) run_d = 1'b0;
            else                   count_d = load_q;
         end else begin
            count_d = count_q - 1'b1;
         end
      end
      // bus writes override the tick path
      if (wr_ctrl) begin
         ctrl_d = ctrl_wr;
         run_d  = ctrl_wr.enable;
         count_d = ctrl_wr.enable ? load_q : count_q;
      end
      if (wr_load) begin
         load_d = wdata_i;
         if (ctrl_q.enable) begin
            count_d = wdata_i;
            run_d   = 1'b1;
         end
      end
      if (wr_staged) begin
         staged_d = wdata_i;
         load_d   = wdata_i;
      end
      if (wr_raw && wdata_i[0]) raw_d = 1'b0;
      // expiry wins over a same-cycle clear
      if (expire) raw_d = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         count_q  <= '0;
         load_q   <= '0;
         staged_q <= '0;
         ctrl_q   <= '0;
         raw_q    <= 1'b0;
         run_q    <= 1'b0;
      end else begin
         count_q  <= count_d;
         load_q   <= load_d;
         staged_q <= staged_d;
         ctrl_q   <= ctrl_d;
         raw_q    <= raw_d;
         run_q    <= run_d;
      end
   end

   assign irq_o = raw_q && ctrl_q.irq_en;

   always_comb begin
      unique case (ridx_i)
         REG_VALUE:  rd_word_o = count_q;
         REG_LOAD:   rd_word_o = load_q;
         REG_STAGED: rd_word_o = staged_q;
         REG_CTRL:   rd_word_o = DATA_W'(ctrl_q);
         REG_RAW:    rd_word_o = DATA_W'(raw_q);
         REG_MASKED: rd_word_o = DATA_W'(irq_o);
         default:    rd_word_o = '0;
      endcase
   end

   AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && tick_en_i && count_q != '0 && !wr_ctrl && !wr_load) |=> (count_q == $past(count_q) - 1'b1)); // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_en_i && !wr_ctrl && !wr_load) |=> $stable(count_q)); // R9
   AST_EXPIRE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire |=> raw_q); // R10
   AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_raw && wdata_i[0] && !expire) |=> !raw_q); // R5
   AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_raw && !wdata_i[0] && raw_q) |=> raw_q); // R5
   AST_SINGLE_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire && ctrl_q.single_run && !wr_ctrl && !wr_load) |=> (count_q == '0 && !run_q)); // R11
   AST_STAGED_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_staged && !tick_en_i) |=> $stable(count_q)); // R8

endmodule

// File: rtl/dual_tick_timer.sv
`timescale 1ns/1ps
module dual_tick_timer
   import dtmr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int N_TIMERS = 2,
   parameter int ADDR_W   = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                tick_en_i,
   input  logic                bus_wr_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic [N_TIMERS-1:0] irq_o
);

   localparam int TSEL_W       = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1;
   localparam int WINDOW_BYTES = N_TIMERS * REGS_PER_TIMER * 4;

   if (DATA_W < CTL_W) begin : g_chk_data
      $error("DATA_W must hold the control field");
   end
   if (N_TIMERS < 1) begin : g_chk_count
      $error("N_TIMERS must be at least 1");
   end
   if (ADDR_W < 3 || ADDR_W > 30) begin : g_chk_aw
      $error("ADDR_W out of range");
   end else if ((64'd1 << ADDR_W) < 64'(WINDOW_BYTES)) begin : g_chk_window
      $error("ADDR_W too narrow for the register window");
   end

   logic              hit;
   logic [TSEL_W-1:0] tsel;
   reg_idx_e          ridx;
   logic [DATA_W-1:0] rd_words [N_TIMERS];

   dtmr_decode #(
      .ADDR_W  (ADDR_W),
      .N_TIMERS(N_TIMERS),
      .TSEL_W  (TSEL_W)
   ) u_decode (
      .addr_i(bus_addr_i),
      .hit_o (hit),
      .tsel_o(tsel),
      .ridx_o(ridx)
   );

   for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
      logic wr_sel;
      assign wr_sel = bus_wr_i && hit && (tsel == TSEL_W'(g));

      dtmr_channel #(
         .DATA_W(DATA_W)
      ) u_channel (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .tick_en_i(tick_en_i),
         .wr_i     (wr_sel),
         .ridx_i   (ridx),
         .wdata_i  (bus_wdata_i),
         .rd_word_o(rd_words[g]),
         .irq_o    (irq_o[g])
      );
   end

   assign bus_rdata_o = hit ? rd_words[tsel] : '0;

endmodule

// File: tb/dual_tick_timer_bench.sv
`timescale 1ns/1ps
module dual_tick_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] m_cnt [2];
   logic [31:0] m_load [2];
   logic [31:0] m_stg [2];
   logic [2:0]  m_ctrl [2];
   logic        m_raw [2];

   always #2 clk = ~clk;

   dual_tick_timer #(.DATA_W(32), .N_TIMERS(2), .ADDR_W(8)) u_dual_tick_timer (
      .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .irq_o(irq)
   );

   function automatic logic [7:0] ba(input int t, input int r);
      return 8'((t * 6 + r) * 4);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; tick_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; tick_en = 1'b0;
   endtask

   task automatic tick(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] d, e;
      logic [1:0]  mis;
      for (int t = 0; t < 2; t++) begin
         mis[t] = m_raw[t] & m_ctrl[t][1];
         for (int r = 0; r < 6; r++) begin
            case (r)
               0: e = m_cnt[t];
               1: e = m_load[t];
               2: e = m_stg[t];
               3: e = {29'd0, m_ctrl[t]};
               4: e = {31'd0, m_raw[t]};
               default: e = {31'd0, mis[t]};
            endcase
            rd(ba(t, r), d);
            chk($sformatf("%s t%0d w%0d", tag, t, r), d, e);
         end
      end
      chk({tag, " R4 irq"}, {30'd0, irq}, {30'd0, mis});
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      for (int t = 0; t < 2; t++) begin
         m_cnt[t] = '0; m_load[t] = '0; m_stg[t] = '0; m_ctrl[t] = '0; m_raw[t] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1 reset");

      // R2: every byte address beyond the window reads zero
      for (int a = 48; a < 256; a++) begin
         rd(8'(a), d);
         chk($sformatf("R2 oor read %0h", a), d, 32'd0);
      end

      // R1/R8 staged load sweep
      for (int t = 0; t < 2; t++) begin
         wr(ba(t, 2), 32'hB0B0_0000 + 32'(t));
         m_stg[t] = 32'hB0B0_0000 + 32'(t); m_load[t] = m_stg[t];
      end
      check_all("R1 R8 staged sweep");

      // R3: low address bits ignored on write
      for (int t = 0; t < 2; t++) begin
         wr(ba(t, 1) + 8'(t + 1), 32'h00A0_0000 + 32'(t));
         m_load[t] = 32'h00A0_0000 + 32'(t);
      end
      check_all("R3 R1 load sweep");

      // R2: writes beyond the window are dropped
      for (int a = 48; a < 256; a += 4) wr(8'(a), 32'hFFFF_FFFF);
      check_all("R2 oor write");

      // R12: read-only words
      wr(ba(0, 0), 32'd123); wr(ba(0, 5), 32'd1);
      wr(ba(1, 0), 32'd77);  wr(ba(1, 5), 32'hFFFF_FFFF);
      check_all("R12 read-only");

      // R6: enable reloads count; upper control bits read zero
      wr(ba(0, 1), 32'd5); m_load[0] = 32'd5;
      wr(ba(0, 3), 32'hFFFF_FFF3); m_ctrl[0] = 3'b011; m_cnt[0] = 32'd5;
      check_all("R6 enable reload");

      tick(3); m_cnt[0] = 32'd2;
      check_all("R9 count down");
      tick(2); m_cnt[0] = 32'd0;
      check_all("R9 reach zero");
      tick(1); m_cnt[0] = 32'd5; m_raw[0] = 1'b1;
      check_all("R10 expire reload");

      wr(ba(0, 4), 32'd0);
      check_all("R5 write zero keeps");
      wr(ba(0, 4), 32'd1); m_raw[0] = 1'b0;
      check_all("R5 write one clears");

      // R4: interrupt masked with enable only
      wr(ba(0, 3), 32'd1); m_ctrl[0] = 3'b001; m_cnt[0] = 32'd5;
      tick(6); m_raw[0] = 1'b1;
      check_all("R4 masked irq");

      // R5: expiry beats a same-cycle clear
      wr(ba(0, 4), 32'd1); m_raw[0] = 1'b0;
      tick(5); m_cnt[0] = 32'd0;
      wr_tick(ba(0, 4), 32'd1); m_raw[0] = 1'b1; m_cnt[0] = 32'd5;
      check_all("R5 expiry wins");

      // R8: staged write keeps the running count
      tick(2); m_cnt[0] = 32'd3;
      wr(ba(0, 2), 32'd9); m_stg[0] = 32'd9; m_load[0] = 32'd9;
      check_all("R8 staged no restart");
      tick(4); m_cnt[0] = 32'd9;
      check_all("R8 R10 staged next reload");

      // R7: load while enabled restarts
      wr(ba(0, 1), 32'd20); m_load[0] = 32'd20; m_cnt[0] = 32'd20;
      check_all("R7 enabled load");

      // R6: disable stops the count
      wr(ba(0, 3), 32'd0); m_ctrl[0] = 3'b000;
      tick(5);
      check_all("R6 stop holds");
      wr(ba(0, 1), 32'd7); m_load[0] = 32'd7;
      check_all("R7 disabled load");

      // R11: single-run on the second timer
      wr(ba(1, 1), 32'd2); m_load[1] = 32'd2;
      wr(ba(1, 3), 32'd7); m_ctrl[1] = 3'b111; m_cnt[1] = 32'd2;
      tick(3); m_cnt[1] = 32'd0; m_raw[1] = 1'b1;
      tick(4);
      check_all("R11 single-run halt");
      wr(ba(1, 1), 32'd4); m_load[1] = 32'd4; m_cnt[1] = 32'd4;
      tick(1); m_cnt[1] = 32'd3;
      check_all("R11 R7 single-run restart");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule